// File: doc/BRIEF.md
# Multi-Pin Waveform Sample Packer and Player

This block captures and replays digital waveforms on one, two or four pins. In capture direction it takes a sample of the selected pins each time a strobe fires, packs the samples into 32-bit words and offers each completed word on a valid/ready stream to a memory writer. In playback direction it accepts words from a valid/ready stream, unpacks them in the same order, and drives the pins with one group of bits per strobe. The same word format serves both directions, so a captured word list can be played back unchanged.

The strobe comes from one of several asynchronous source inputs. These can be external clock inputs or a copy of another pin. Each source passes through a two-stage synchroniser, and its rising edge becomes a single-cycle enable in the system clock domain. The data pins go through the same synchroniser, so a sample shows the pin levels of the cycle in which the source rose. Configuration (direction, lane count, strobe source) is taken only while the unit is disabled. Two sticky flags report words lost in capture and strobes that found no data in playback.

Top module: `sp_packer_player`

## Requirements
- R1: Direction, lane code and strobe source are latched only on clock edges where `en_i` is low. Changes to these inputs while `en_i` is high have no effect until the next disable.
- R2: One sample or one output update happens per rising edge of the selected source `src_i[src_sel]`. Each rise takes effect exactly once, and captured pin values are those present in the cycle of the rise.
- R3: In capture, the k-th sample since enable (counted from 0 within a word) with n lanes places pin i at word bit k*n+i. Lane code 0 means n=1, code 1 means n=2, codes 2 and 3 mean n=4. A word holds 32/n samples.
- R4: A completed capture word appears on `cap_data_o` with `cap_valid_o` high. Both hold unchanged until `cap_ready_i` is seen high.
- R5: If a word completes while the previous word is still unaccepted, the new word is dropped and `overflow_o` is set. The flag stays set until the next enable.
- R6: In playback, the k-th strobe on a word drives `pin_o[i]` from word bit k*n+i, with lanes at index n and above driven 0. `pin_oe_o` shows the lane mask (0001, 0011 or 1111) while enabled in playback direction, and is 0 otherwise.
- R7: A playback strobe that finds no buffered word leaves `pin_o` unchanged and sets `underflow_o`, which stays set until the next enable.
- R8: The first enabled cycle after `en_i` rises clears the bit position, the playback buffer, `pin_o` and both flags.
- R9: `play_ready_o` is high only while enabled in playback direction with no word buffered. A word is taken on a cycle where valid and ready are both high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Unit enable |
| dir_i | input | 1 | 0 = capture, 1 = playback (latched while disabled) |
| lanes_i | input | 2 | Lane code (latched while disabled) |
| src_sel_i | input | 2 | Strobe source select (latched while disabled) |
| src_i | input | 4 | Asynchronous strobe sources |
| pin_i | input | 4 | Pins sampled in capture |
| pin_o | output | 4 | Pin levels in playback |
| pin_oe_o | output | 4 | Pin output enables |
| cap_data_o | output | 32 | Captured word |
| cap_valid_o | output | 1 | Captured word valid |
| cap_ready_i | input | 1 | Captured word accepted |
| play_data_i | input | 32 | Word to play |
| play_valid_i | input | 1 | Word to play valid |
| play_ready_o | output | 1 | Playback buffer empty and accepting |
| overflow_o | output | 1 | Sticky capture overflow |
| underflow_o | output | 1 | Sticky playback underflow |

## Verification
The assertions assume the strobe source select stays unchanged while a strobe is in flight. They also assume no source toggles faster than the synchroniser can see, so each level lasts at least two system clocks. The stimulus holds every source high for two cycles and low for two cycles per strobe. It changes configuration only through disable and enable, apart from one deliberate lane-code change made while enabled. It holds the pin data steady across each strobe window, so the packed and unpacked values are unambiguous.

// File: rtl/sp_pkg.sv
`timescale 1ns/1ps
package sp_pkg;
    localparam int unsigned MAX_LANES = 4;

    typedef enum logic [1:0] {
        LN_ONE      = 2'd0,
        LN_TWO      = 2'd1,
        LN_FOUR     = 2'd2,
        LN_FOUR_ALT = 2'd3
    } lane_mode_e;

    function automatic logic [2:0] lane_count(input lane_mode_e m);
        case (m)
            LN_ONE:  return 3'd1;
            LN_TWO:  return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic [MAX_LANES-1:0] lane_mask(input lane_mode_e m);
        case (m)
            LN_ONE:  return 4'b0001;
            LN_TWO:  return 4'b0011;
            default: return 4'b1111;
        endcase
    endfunction
endpackage

// File: rtl/sp_strobe_gen.sv
`timescale 1ns/1ps
module sp_strobe_gen #(
    parameter int NSRC   = 4,
    parameter int NPIN   = 4,
    parameter int STAGES = 2,
    localparam int SEL_W = $clog2(NSRC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  src_i,
    input  logic [NPIN-1:0]  pin_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             strobe_o,
    output logic [NPIN-1:0]  pin_s_o
);
    localparam int W = NSRC + NPIN;

    typedef struct packed {
        logic [STAGES-1:0][W-1:0] chain;
        logic [NSRC-1:0]          last;
    } st_t;

    st_t q, d;
    logic [NSRC-1:0] srcs_s;

    always_comb begin
        d          = q;
        d.chain[0] = {pin_i, src_i};
        for (int s = 1; s < STAGES; s++) begin
            d.chain[s] = q.chain[s-1];
        end
        d.last = q.chain[STAGES-1][NSRC-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign srcs_s   = q.chain[STAGES-1][NSRC-1:0];
    assign pin_s_o  = q.chain[STAGES-1][W-1:NSRC];
    assign strobe_o = srcs_s[sel_i] & ~q.last[sel_i];

    // R2: a rising edge gives a single-cycle enable
    p_strobe_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |=> (!$stable(sel_i) || !strobe_o));
endmodule

// File: rtl/sp_capture.sv
`timescale 1ns/1ps
module sp_capture
    import sp_pkg::*;
#(
    parameter int WORD_W = 32,
    localparam int POS_W = $clog2(WORD_W) + 1,
    localparam int IDX_W = $clog2(WORD_W)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic                 act_i,
    input  logic                 strobe_i,
    input  lane_mode_e           lanes_i,
    input  logic [MAX_LANES-1:0] pin_i,
    input  logic                 ready_i,
    output logic [WORD_W-1:0]    data_o,
    output logic                 valid_o,
    output logic                 ovf_o
);
    typedef struct packed {
        logic [WORD_W-1:0] acc;
        logic [WORD_W-1:0] data;
        logic              valid;
        logic [POS_W-1:0]  pos;
        logic              ovf;
    } st_t;

    st_t q, d;
    logic [POS_W-1:0] n_s;
    logic [POS_W-1:0] next_pos_s;

    assign n_s        = POS_W'(lane_count(lanes_i));
    assign next_pos_s = q.pos + n_s;

    always_comb begin
        d = q;
        if (q.valid && ready_i) d.valid = 1'b0;
        if (start_i) begin
            d.pos = '0;
            d.acc = '0;
            d.ovf = 1'b0;
        end else if (act_i && strobe_i) begin
            for (int i = 0; i < int'(MAX_LANES); i++) begin
                if (i < int'(n_s)) d.acc[IDX_W'(int'(q.pos) + i)] = pin_i[i];
            end
            d.pos = next_pos_s;
            if (next_pos_s == POS_W'(WORD_W)) begin
                if (!d.valid) begin
                    d.valid = 1'b1;
                    d.data  = d.acc;
                end else begin
                    d.ovf = 1'b1;
                end
                d.pos = '0;
                d.acc = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign data_o  = q.data;
    assign valid_o = q.valid;
    assign ovf_o   = q.ovf;

    // R4: an offered word stays put until taken
    p_hold_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && !ready_i |=> valid_o && $stable(data_o));
    // R5: overflow flag is sticky until a new enable
    p_ovf_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o && !start_i |=> ovf_o);
endmodule

// File: rtl/sp_playback.sv
`timescale 1ns/1ps
module sp_playback
    import sp_pkg::*;
#(
    parameter int WORD_W = 32,
    localparam int POS_W = $clog2(WORD_W) + 1,
    localparam int IDX_W = $clog2(WORD_W)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic                 act_i,
    input  logic                 strobe_i,
    input  lane_mode_e           lanes_i,
    input  logic [WORD_W-1:0]    data_i,
    input  logic                 valid_i,
    output logic                 ready_o,
    output logic [MAX_LANES-1:0] pins_o,
    output logic                 unf_o
);
    typedef struct packed {
        logic [WORD_W-1:0]    hold_word;
        logic                 have;
        logic [POS_W-1:0]     pos;
        logic [MAX_LANES-1:0] pins;
        logic                 unf;
    } st_t;

    st_t q, d;
    logic [POS_W-1:0] n_s;
    logic [POS_W-1:0] next_pos_s;

    assign n_s        = POS_W'(lane_count(lanes_i));
    assign next_pos_s = q.pos + n_s;
    assign ready_o    = act_i & ~q.have;

    always_comb begin
        d = q;
        if (start_i) begin
            d.have = 1'b0;
            d.pos  = '0;
            d.pins = '0;
            d.unf  = 1'b0;
        end else begin
            if (act_i && strobe_i) begin
                if (q.have) begin
                    for (int i = 0; i < int'(MAX_LANES); i++) begin
                        d.pins[i] = (i < int'(n_s)) ? q.hold_word[IDX_W'(int'(q.pos) + i)] : 1'b0;
                    end
                    d.pos = next_pos_s;
                    if (next_pos_s == POS_W'(WORD_W)) begin
                        d.have = 1'b0;
                        d.pos  = '0;
                    end
                end else begin
                    d.unf = 1'b1;
                end
            end
            if (valid_i && ready_o) begin
                d.have      = 1'b1;
                d.hold_word = data_i;
                d.pos       = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pins_o = q.pins;
    assign unf_o  = q.unf;

    // R7: a starved strobe keeps the pins and raises the flag
    p_underflow_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        act_i && strobe_i && !q.have && !start_i |=> $stable(pins_o) && unf_o);
    // R9: a handshake fills the buffer
    p_load_fill_r9: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i && ready_o && !start_i |=> !ready_o);
endmodule

// File: rtl/sp_packer_player.sv
`timescale 1ns/1ps
module sp_packer_player
    import sp_pkg::*;
#(
    parameter int WORD_W      = 32,
    parameter int NSRC        = 4,
    parameter int SYNC_STAGES = 2,
    localparam int SEL_W      = $clog2(NSRC)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en_i,
    input  logic                 dir_i,
    input  logic [1:0]           lanes_i,
    input  logic [SEL_W-1:0]     src_sel_i,
    input  logic [NSRC-1:0]      src_i,
    input  logic [MAX_LANES-1:0] pin_i,
    output logic [MAX_LANES-1:0] pin_o,
    output logic [MAX_LANES-1:0] pin_oe_o,
    output logic [WORD_W-1:0]    cap_data_o,
    output logic                 cap_valid_o,
    input  logic                 cap_ready_i,
    input  logic [WORD_W-1:0]    play_data_i,
    input  logic                 play_valid_i,
    output logic                 play_ready_o,
    output logic                 overflow_o,
    output logic                 underflow_o
);
    typedef struct packed {
        logic             en;
        logic             dir;
        lane_mode_e       lanes;
        logic [SEL_W-1:0] sel;
    } cfg_t;

    cfg_t q, d;
    logic start_s, run_s, strobe_s;
    logic [MAX_LANES-1:0] pin_s;

    always_comb begin
        d    = q;
        d.en = en_i;
        if (!en_i) begin
            d.dir   = dir_i;
            d.lanes = lane_mode_e'(lanes_i);
            d.sel   = src_sel_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign start_s  = en_i & ~q.en;
    assign run_s    = en_i & q.en;
    assign pin_oe_o = (q.en && q.dir) ? lane_mask(q.lanes) : '0;

    sp_strobe_gen #(.NSRC(NSRC), .NPIN(MAX_LANES), .STAGES(SYNC_STAGES)) u_strobe (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_i    (src_i),
        .pin_i    (pin_i),
        .sel_i    (q.sel),
        .strobe_o (strobe_s),
        .pin_s_o  (pin_s)
    );

    sp_capture #(.WORD_W(WORD_W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_s),
        .act_i    (run_s & ~q.dir),
        .strobe_i (strobe_s),
        .lanes_i  (q.lanes),
        .pin_i    (pin_s),
        .ready_i  (cap_ready_i),
        .data_o   (cap_data_o),
        .valid_o  (cap_valid_o),
        .ovf_o    (overflow_o)
    );

    sp_playback #(.WORD_W(WORD_W)) u_play (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_s),
        .act_i    (run_s & q.dir),
        .strobe_i (strobe_s),
        .lanes_i  (q.lanes),
        .data_i   (play_data_i),
        .valid_i  (play_valid_i),
        .ready_o  (play_ready_o),
        .pins_o   (pin_o),
        .unf_o    (underflow_o)
    );

    // R1: configuration frozen while enabled
    p_cfg_frozen_r1: assert property (@(posedge clk) disable iff (!rst_n)
        en_i |=> $stable(q.dir) && $stable(q.lanes) && $stable(q.sel));
    // R8: flags cleared on the first enabled cycle
    p_start_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start_s |=> !overflow_o && !underflow_o);
endmodule

// File: tb/sp_packer_player_tb.sv
`timescale 1ns/1ps
module sp_packer_player_tb;
    localparam int CLK_P = 10;

    logic clk = 1'b0, rst_n = 1'b0;
    logic en_i = 0, dir_i = 0, cap_ready_i = 0, play_valid_i = 0;
    logic [1:0] lanes_i = 0, src_sel_i = 0;
    logic [3:0] src_i = 0, pin_i = 0;
    logic [31:0] play_data_i = 0;
    logic [3:0] pin_o, pin_oe_o;
    logic [31:0] cap_data_o;
    logic cap_valid_o, play_ready_o, overflow_o, underflow_o;

    int nchk = 0, nerr = 0, cycles = 0;
    int pidx = 0, pcount = 0;
    logic [31:0] parr [8];

    always #(CLK_P/2) clk = ~clk;

    sp_packer_player u_dut (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .dir_i(dir_i), .lanes_i(lanes_i),
        .src_sel_i(src_sel_i), .src_i(src_i), .pin_i(pin_i), .pin_o(pin_o),
        .pin_oe_o(pin_oe_o), .cap_data_o(cap_data_o), .cap_valid_o(cap_valid_o),
        .cap_ready_i(cap_ready_i), .play_data_i(play_data_i), .play_valid_i(play_valid_i),
        .play_ready_o(play_ready_o), .overflow_o(overflow_o), .underflow_o(underflow_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // reference model state
    logic m_en_q = 0, m_dir = 0, m_outv = 0, m_ovf = 0, m_have = 0, m_unf = 0;
    logic [1:0] m_lanes = 0, m_sel = 0;
    logic [3:0] h_s1 = 0, h_s2 = 0, h_s3 = 0, h_p1 = 0, h_p2 = 0, m_pin = 0;
    logic [31:0] m_acc = 0, m_outd = 0, m_pbuf = 0;
    int m_cpos = 0, m_ppos = 0;

    always begin
        logic s_rst, s_en, s_dir, s_rdy, s_pv, strb, pready, load;
        logic [1:0] s_lanes, s_sel;
        logic [3:0] s_src, s_pin, mask;
        logic [31:0] s_pd;
        int n;
        @(posedge clk);
        s_rst = rst_n; s_en = en_i; s_dir = dir_i; s_rdy = cap_ready_i; s_pv = play_valid_i;
        s_lanes = lanes_i; s_sel = src_sel_i; s_src = src_i; s_pin = pin_i; s_pd = play_data_i;
        #(CLK_P/4);
        cycles++;
        if (!s_rst) begin
            m_en_q = 0; m_dir = 0; m_outv = 0; m_ovf = 0; m_have = 0; m_unf = 0;
            m_lanes = 0; m_sel = 0; h_s1 = 0; h_s2 = 0; h_s3 = 0; h_p1 = 0; h_p2 = 0;
            m_pin = 0; m_acc = 0; m_outd = 0; m_pbuf = 0; m_cpos = 0; m_ppos = 0;
        end else begin
            strb = h_s2[m_sel] & ~h_s3[m_sel];
            n = (m_lanes == 0) ? 1 : (m_lanes == 1) ? 2 : 4;
            mask = 4'((1 << n) - 1);
            pready = s_en && m_en_q && m_dir && !m_have;
            load = pready && s_pv;
            if (m_outv && s_rdy) m_outv = 0;
            if (s_en && !m_en_q) begin
                m_cpos = 0; m_acc = 0; m_ovf = 0; m_have = 0; m_ppos = 0; m_unf = 0; m_pin = 0;
            end else if (s_en) begin
                if (!m_dir && strb) begin
                    for (int i = 0; i < n; i++) m_acc[m_cpos + i] = h_p2[i];
                    m_cpos += n;
                    if (m_cpos == 32) begin
                        if (!m_outv) begin m_outv = 1; m_outd = m_acc; end
                        else m_ovf = 1;
                        m_cpos = 0; m_acc = 0;
                    end
                end
                if (m_dir) begin
                    if (strb) begin
                        if (m_have) begin
                            m_pin = 4'(m_pbuf >> m_ppos) & mask;
                            m_ppos += n;
                            if (m_ppos == 32) begin m_have = 0; m_ppos = 0; end
                        end else m_unf = 1;
                    end
                    if (load) begin m_have = 1; m_pbuf = s_pd; m_ppos = 0; pidx++; end
                end
            end
            if (!s_en) begin m_dir = s_dir; m_lanes = s_lanes; m_sel = s_sel; end
            m_en_q = s_en;
            h_s3 = h_s2; h_s2 = h_s1; h_s1 = s_src;
            h_p2 = h_p1; h_p1 = s_pin;
            mask = (m_lanes == 0) ? 4'b0001 : (m_lanes == 1) ? 4'b0011 : 4'b1111;
            chk("R4 cap_valid", 32'(cap_valid_o), 32'(m_outv));
            if (m_outv) chk("R3 cap_data", cap_data_o, m_outd);
            chk("R5 overflow", 32'(overflow_o), 32'(m_ovf));
            chk("R6 pin_o", 32'(pin_o), 32'(m_pin));
            chk("R6 pin_oe", 32'(pin_oe_o), 32'((m_en_q && m_dir) ? mask : 4'b0));
            chk("R7 underflow", 32'(underflow_o), 32'(m_unf));
            chk("R9 play_ready", 32'(play_ready_o), 32'(en_i && m_en_q && m_dir && !m_have));
        end
        if (cycles > 150000) begin
            nerr++; nchk++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    always @(negedge clk) begin
        play_valid_i <= (pidx < pcount);
        play_data_i  <= parr[pidx % 8];
    end

    task automatic strobe(input int sel, input logic [3:0] p);
        @(negedge clk); pin_i = p; src_i[sel] = 1'b1;
        repeat (2) @(negedge clk);
        src_i[sel] = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic setup(input logic d, input logic [1:0] ln, input logic [1:0] sel);
        @(negedge clk); en_i = 0; dir_i = d; lanes_i = ln; src_sel_i = sel;
        @(negedge clk); en_i = 1;
        repeat (2) @(negedge clk);
    endtask

    localparam logic [31:0] W1 = 32'hA5C3_0F69;

    initial begin
        parr[0] = 32'h1234_5678; parr[1] = 32'h9ABC_DEF0; parr[2] = 32'hC0DE_F00D;
        parr[3] = 32'h8000_0001; parr[4] = 32'h5A5A_33CC;
        parr[5] = 0; parr[6] = 0; parr[7] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R4 reset valid", 32'(cap_valid_o), 0);
        chk("R6 reset oe", 32'(pin_oe_o), 0);
        chk("R5 reset flags", {30'd0, overflow_o, underflow_o}, 0);

        // R2/R3: one lane, 32 strobes, word held for reading
        setup(0, 2'd0, 2'd0);
        for (int k = 0; k < 32; k++) strobe(0, {3'b0, W1[k]});
        chk("R4 word offered", 32'(cap_valid_o), 1);
        chk("R2 R3 packed word", cap_data_o, W1);
        @(negedge clk); cap_ready_i = 1;
        @(negedge clk);

        // R1: lane change while enabled is ignored
        lanes_i = 2'd2;
        for (int k = 0; k < 8; k++) strobe(0, 4'hF);
        chk("R1 still one lane", 32'(cap_valid_o), 0);
        for (int k = 8; k < 32; k++) strobe(0, 4'(k));
        chk("R1 word after 32", 32'(overflow_o), 0);

        // two lanes, source 1
        setup(0, 2'd1, 2'd1);
        for (int k = 0; k < 16; k++) strobe(1, 4'(k * 3));

        // R5: four lanes, stream stalled across two words
        @(negedge clk); cap_ready_i = 0;
        setup(0, 2'd2, 2'd2);
        for (int k = 0; k < 16; k++) strobe(2, 4'(k + 5));
        chk("R5 overflow set", 32'(overflow_o), 1);
        chk("R5 first word kept", cap_data_o, 32'hC_BA98765);
        @(negedge clk); cap_ready_i = 1;
        // R8: re-enable clears flags
        setup(0, 2'd2, 2'd2);
        chk("R8 flags cleared", 32'(overflow_o), 0);

        // playback four lanes, three words, then starve (R7)
        @(negedge clk); en_i = 0; pidx = 0; pcount = 3;
        setup(1, 2'd3, 2'd3);
        for (int k = 0; k < 24; k++) strobe(3, 4'h0);
        for (int k = 0; k < 2; k++) strobe(3, 4'h0);
        chk("R7 underflow set", 32'(underflow_o), 1);
        chk("R7 pins held", 32'(pin_o), 32'h0000_000C);

        // playback one lane, then two lanes
        @(negedge clk); en_i = 0; pidx = 3; pcount = 4;
        setup(1, 2'd0, 2'd0);
        for (int k = 0; k < 32; k++) strobe(0, 4'h0);
        chk("R6 last one-lane bit", 32'(pin_o), 32'h1);
        @(negedge clk); en_i = 0; pidx = 4; pcount = 5;
        setup(1, 2'd1, 2'd1);
        for (int k = 0; k < 16; k++) strobe(1, 4'h0);
        chk("R6 last two-lane pair", 32'(pin_o), 32'h1);
        chk("R8 no underflow", 32'(underflow_o), 0);
        @(negedge clk); en_i = 0;
        repeat (4) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule